// File: doc/BRIEF.md
# Power-fail chip-enable gating controller

This block sits between the active-low chip-enable produced by an address decoder and an external static RAM that is kept alive by a backup cell. External comparators report, as one digital flag, whether the main supply is inside tolerance. While that flag is high and the block has settled, the decoder's chip-enable reaches the memory through a purely combinational path.

When the supply flag drops, an access that is already under way (chip-enable low) may run to its end. It is never allowed to last longer than a bounded write-protect window. After that the gated output is held high so the memory cannot be written. When the supply comes back, the output stays high for a long recovery interval whatever the decoder does, and only then does pass-through resume. Both windows are counted in clock cycles from parameters.

A threshold-select bit, which picks the tighter or the looser supply tolerance, is handed on in registered form to the comparator side.

Top module: `pfg_ctrl`

## Requirements
- R1: In the pass state, `cecon_n` equals `ce_n` in the same cycle, with no register in the path.
- R2: While `rst` is high and after it falls, the block is in the recover state with `cecon_n` high. With `pwr_ok` held high, it stays there for exactly CER_CYCLES cycles (counting the cycle in which `rst` falls) and enters the pass state on the next cycle.
- R3: In the pass state, a clock edge that samples `pwr_ok` low with `ce_n` high moves the block to the protect state. There `cecon_n` is high whatever `ce_n` does.
- R4: In the pass state, a clock edge that samples `pwr_ok` low with `ce_n` low moves the block to the drain state. In the drain state `cecon_n` follows `ce_n`. The first edge that samples `ce_n` high moves the block to the protect state.
- R5: The block spends at most WPT_CYCLES cycles in the drain state. If `ce_n` is still low, it then enters the protect state and drives `cecon_n` high.
- R6: In the protect state, an edge that samples `pwr_ok` high moves the block to the recover state. The recover state lasts CER_CYCLES cycles with `cecon_n` high, ignoring `ce_n`, and is followed by the pass state.
- R7: In the recover state, an edge that samples `pwr_ok` low moves the block to the protect state, with no drain window. This takes priority over finishing the recovery in that same cycle.
- R8: `thr_sel_o` is the value of `thr_sel` sampled at the previous clock edge and is 0 after reset.
- R9: `state_o` encodes the states as pass = 0, drain = 1, protect = 2, recover = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip-enable from the address decoder, active low |
| pwr_ok | input | 1 | Supply-in-tolerance flag from the comparators |
| thr_sel | input | 1 | Tolerance select: 0 tight, 1 loose |
| cecon_n | output | 1 | Gated chip-enable to the memory, active low |
| thr_sel_o | output | 1 | Registered tolerance select for the comparators |
| state_o | output | 2 | Controller state (encoding in R9) |

## Verification
Two collisions are forced on a single edge. In the first, the supply flag drops in the very last cycle of the recovery interval, so completing the hold-off and re-entering protection are both due at once. The bench expects the protect state on the following cycle, never the pass state. In the second, chip-enable stays low through the whole drain window, so the timeout, and not the end of the access, is what ends the drain. The bench checks the exact cycle in which the output turns high while the input is still low.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_PROTECT = 2'd2,
        ST_RECOVER = 2'd3
    } pfg_state_e;

    typedef struct packed {
        logic pwr_ok;
        logic ce_n;
    } pfg_in_t;

    // States in which the shared interval counter advances
    function automatic logic is_timed(pfg_state_e s);
        return (s == ST_DRAIN) || (s == ST_RECOVER);
    endfunction

    // States in which the decoder's chip-enable reaches the memory
    function automatic logic lets_through(pfg_state_e s);
        return (s == ST_PASS) || (s == ST_DRAIN);
    endfunction

    function automatic int unsigned larger(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfg_timer.sv
module pfg_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          at_limit
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && !at_limit) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign at_limit = (cnt == limit);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= limit));

endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
    import pfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pfg_in_t    din,
    input  logic       at_limit,
    output pfg_state_e st,
    output logic       restart
);
    pfg_state_e nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_PASS: begin
                if (!din.pwr_ok) begin
                    nxt = din.ce_n ? ST_PROTECT : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (din.ce_n || at_limit) begin
                    nxt = ST_PROTECT;
                end
            end
            ST_PROTECT: begin
                if (din.pwr_ok) begin
                    nxt = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (!din.pwr_ok) begin
                    nxt = ST_PROTECT;
                end else if (at_limit) begin
                    nxt = ST_PASS;
                end
            end
            default: nxt = ST_PROTECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_RECOVER;
        end else begin
            st <= nxt;
        end
    end

    assign restart = (nxt != st);

    // R3
    idle_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PASS && !din.pwr_ok && din.ce_n) |=> (st == ST_PROTECT));

    // R4
    drain_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN && din.ce_n) |=> (st == ST_PROTECT));

    // R6
    recover_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PROTECT && din.pwr_ok) |=> (st == ST_RECOVER));

    // R7
    refail_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RECOVER && !din.pwr_ok) |=> (st == ST_PROTECT));

endmodule

// File: rtl/pfg_outstage.sv
module pfg_outstage
    import pfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pfg_state_e st,
    input  logic       ce_n,
    input  logic       thr_sel,
    output logic       cecon_n,
    output logic       thr_sel_o
);
    assign cecon_n = lets_through(st) ? ce_n : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_sel_o <= 1'b0;
        end else begin
            thr_sel_o <= thr_sel;
        end
    end

    // R8
    thr_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (thr_sel_o == $past(thr_sel)));

endmodule

// File: rtl/pfg_ctrl.sv
module pfg_ctrl
    import pfg_pkg::*;
#(
    parameter int unsigned WPT_CYCLES = 16,
    parameter int unsigned CER_CYCLES = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  logic       pwr_ok,
    input  logic       thr_sel,
    output logic       cecon_n,
    output logic       thr_sel_o,
    output logic [1:0] state_o
);
    localparam int unsigned MAXC = larger(WPT_CYCLES, CER_CYCLES);
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WPT_LIM = CW'(WPT_CYCLES - 1);
    localparam logic [CW-1:0] CER_LIM = CW'(CER_CYCLES - 1);

    pfg_state_e    st;
    pfg_in_t       din;
    logic          restart;
    logic          at_limit;
    logic [CW-1:0] limit;

    assign din.pwr_ok = pwr_ok;
    assign din.ce_n   = ce_n;
    assign limit      = (st == ST_DRAIN) ? WPT_LIM : CER_LIM;

    pfg_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .at_limit (at_limit),
        .st       (st),
        .restart  (restart)
    );

    pfg_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .run      (is_timed(st)),
        .limit    (limit),
        .at_limit (at_limit)
    );

    pfg_outstage u_out (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .ce_n      (ce_n),
        .thr_sel   (thr_sel),
        .cecon_n   (cecon_n),
        .thr_sel_o (thr_sel_o)
    );

    assign state_o = st;

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0) |-> (cecon_n == ce_n));

    // R6
    hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3) |-> cecon_n);

endmodule

// File: tb/sim_pfg_ctrl.sv
module sim_pfg_ctrl;
    localparam int WPT = 5;
    localparam int CER = 8;
    localparam logic [1:0] S_PASS = 2'd0, S_DRAIN = 2'd1,
                           S_PROT = 2'd2, S_REC = 2'd3;

    // entry: {pwr_ok, ce_n, expected state[1:0], expected cecon_n}
    localparam logic [4:0] VEC [0:8] = '{
        {1'b1, 1'b1, S_PASS,  1'b1},
        {1'b1, 1'b0, S_PASS,  1'b0},
        {1'b1, 1'b1, S_PASS,  1'b1},
        {1'b0, 1'b0, S_PASS,  1'b0},
        {1'b0, 1'b0, S_DRAIN, 1'b0},
        {1'b0, 1'b1, S_DRAIN, 1'b1},
        {1'b0, 1'b0, S_PROT,  1'b1},
        {1'b1, 1'b0, S_PROT,  1'b1},
        {1'b1, 1'b0, S_REC,   1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1;
    logic pwr_ok = 1'b1;
    logic thr_sel = 1'b0;
    logic cecon_n, thr_sel_o;
    logic [1:0] state_o;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pfg_ctrl #(.WPT_CYCLES(WPT), .CER_CYCLES(CER)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .pwr_ok(pwr_ok),
        .thr_sel(thr_sel), .cecon_n(cecon_n), .thr_sel_o(thr_sel_o),
        .state_o(state_o)
    );

    task automatic step(input logic p, input logic c);
        @(negedge clk);
        pwr_ok = p;
        ce_n = c;
        #1;
    endtask

    task automatic chk(input string req, input logic [1:0] es, input logic eo);
        checks++;
        if (state_o !== es || cecon_n !== eo) begin
            errors++;
            $display("FAIL %s: state=%0d cecon_n=%b expected state=%0d cecon_n=%b",
                     req, state_o, cecon_n, es, eo);
        end
    endtask

    task automatic chk_thr(input string req, input logic e);
        checks++;
        if (thr_sel_o !== e) begin
            errors++;
            $display("FAIL %s: thr_sel_o=%b expected %b", req, thr_sel_o, e);
        end
    endtask

    // current cycle is recover cycle 1 with pwr_ok=1, ce_n=0 applied
    task automatic hold_check(input string req);
        for (int i = 0; i < CER; i++) begin
            chk(req, S_REC, 1'b1);
            step(1'b1, 1'b0);
        end
        chk(req, S_PASS, 1'b0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R2 reset state
        step(1'b1, 1'b0);
        chk("R2 in reset", S_REC, 1'b1);
        chk_thr("R8 reset value", 1'b0);
        step(1'b1, 1'b0);
        chk("R9 recover code in reset", S_REC, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        hold_check("R2 recovery after reset");

        // table walk: R1, R4, R6
        for (int k = 0; k < 9; k++) begin
            step(VEC[k][4], VEC[k][3]);
            chk($sformatf("R1/R4/R6 vector %0d", k), VEC[k][2:1], VEC[k][0]);
        end
        hold_check("R6 recovery length");

        // R5 drain timeout with access never ending
        step(1'b0, 1'b0);
        chk("R5 fail seen", S_PASS, 1'b0);
        for (int i = 0; i < WPT; i++) begin
            step(1'b0, 1'b0);
            chk("R5 drain window", S_DRAIN, 1'b0);
        end
        step(1'b0, 1'b0);
        chk("R5 timeout forces high", S_PROT, 1'b1);

        // R7 power fails in the last recovery cycle
        step(1'b1, 1'b0);
        chk("R6 protect sees power", S_PROT, 1'b1);
        step(1'b1, 1'b0);
        chk("R6 recover cycle 1", S_REC, 1'b1);
        for (int i = 2; i < CER; i++) begin
            step(1'b1, 1'b0);
            chk("R6 recover hold", S_REC, 1'b1);
        end
        step(1'b0, 1'b0);
        chk("R7 last recover cycle", S_REC, 1'b1);
        step(1'b0, 1'b0);
        chk("R7 refail wins", S_PROT, 1'b1);
        step(1'b1, 1'b0);
        chk("R7 protect", S_PROT, 1'b1);
        step(1'b1, 1'b0);
        hold_check("R6 recovery after refail");

        // R3 idle power fail
        step(1'b1, 1'b1);
        chk("R3 idle pass", S_PASS, 1'b1);
        step(1'b0, 1'b1);
        chk("R3 fail seen idle", S_PASS, 1'b1);
        step(1'b0, 1'b0);
        chk("R3 protect ignores ce_n", S_PROT, 1'b1);
        step(1'b0, 1'b0);
        chk("R3 protect stays", S_PROT, 1'b1);

        // R8 threshold select forwarding
        @(negedge clk);
        thr_sel = 1'b1;
        #1;
        chk_thr("R8 not yet forwarded", 1'b0);
        step(1'b0, 1'b0);
        chk_thr("R8 forwarded", 1'b1);
        thr_sel = 1'b0;
        step(1'b0, 1'b0);
        chk_thr("R8 cleared", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule